// File: doc/BRIEF.md
# Software Alert and NMI Control

This block is a small register-mapped controller that produces alert event pulses and a non-maskable interrupt request for a processor core. It sorts alerts into four classes: fatal software, recoverable software, fatal hardware and recoverable hardware. Each class has one pulse output. Software can force a single event of any class through a write-only test register. Two 4-bit fields encoded as multi-bit booleans request software alerts. The recoverable field fires once and then returns to false. The fatal field can only lose bits, and once it leaves false it raises a fatal event on every cycle until reset.

Hardware alert causes come straight from the core. These are a minor alert, a major internal alert, a major bus alert, a double-fault indication and a bus integrity error. The core's watchdog NMI request also enters here. Two NMI sources are kept, an alert source and a watchdog source. Each source has a state bit that software clears by writing 1 and an enable bit that software can only set. The NMI output is raised whenever a source has both its state bit and its enable bit set.

The asynchronous active-low reset is released through a two-stage synchronizer, so register state leaves reset two clock edges after the reset input rises.

Top module: `swalert_nmi_ctrl`

## Requirements
- R1: After reset, the recoverable field (offset 0x04) and the fatal field (offset 0x08) read 0x9. The NMI enable register (0x4C) and the NMI state register (0x50) read 0. `alert_evt_o` and `nmi_o` are 0.
- R2: A write to offset 0x00 with bit k of the write data set drives `alert_evt_o[k]` high for exactly the next cycle. The classes are k=0 fatal software, k=1 recoverable software, k=2 fatal hardware and k=3 recoverable hardware. Offset 0x00 always reads 0.
- R3: Writing any value other than 4'b1001 (false) to the recoverable field loads that value. In the following cycle it produces one `alert_evt_o[1]` pulse, which appears two edges after the write, and the field then reads 4'b1001 again. Writing 4'b1001 produces no event.
- R4: A write to the fatal field stores the old value ANDed with write data bits [3:0]. A bit of the field that has been cleared is never set again before reset.
- R5: While the fatal field differs from 4'b1001, `alert_evt_o[0]` is high on every cycle, starting one edge after the field changes.
- R6: A major internal alert, major bus alert, double fault or bus integrity error input drives `alert_evt_o[2]` high one cycle later. A minor alert input drives `alert_evt_o[3]` high one cycle later. With no cause present, the outputs stay low.
- R7: Offset 0x4C holds the NMI enables: bit 0 for the alert source and bit 1 for the watchdog source. Writing 1 sets a bit, writing 0 has no effect, and a set bit stays set until reset.
- R8: Offset 0x50 holds the NMI state bits: bit 0 for the alert source and bit 1 for the watchdog source. The alert bit sets on any alert event of any class. The watchdog bit sets while `wdog_nmi_i` is high. Both bits set whatever the enable setting. Writing 1 clears a bit, and a set in the same cycle wins over the clear.
- R9: `nmi_o` is high exactly when some source has both its state bit and its enable bit set.
- R10: Reserved bits read 0. Unmapped offsets read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | AddrWidth (8) | Byte offset of the accessed register |
| reg_wdata_i | input | DataWidth (32) | Write data |
| reg_rdata_o | output | DataWidth (32) | Read data for `reg_addr_i`, combinational |
| core_minor_alert_i | input | 1 | Core minor alert (recoverable hardware cause) |
| core_major_int_alert_i | input | 1 | Core major internal alert |
| core_major_bus_alert_i | input | 1 | Core major bus alert |
| core_double_fault_i | input | 1 | Core double-fault indication |
| bus_intg_err_i | input | 1 | Bus response integrity error |
| wdog_nmi_i | input | 1 | Watchdog NMI request |
| alert_evt_o | output | 4 | One event pulse per alert class |
| nmi_o | output | 1 | NMI request to the core |

## Verification
The assertions assume that every input is synchronous to `clk_i` and stable around the rising edge. They also assume that `reg_addr_i` carries a word-aligned byte offset and that at most one register write happens per cycle. The stimulus changes inputs only one time unit after a rising edge. It issues a single write per cycle. The random phase covers the test register, the NMI enable and state registers and the hardware causes, and leaves out the two multi-bit fields. The fatal field is one-way, so it is exercised only by a directed sequence at the end, where its permanent firing cannot disturb the predictions for earlier stimulus.

// File: rtl/swalert_pkg.sv
package swalert_pkg;

  localparam int unsigned MubiW = 4;
  localparam logic [MubiW-1:0] MubiFalse = 4'b1001;
  localparam logic [MubiW-1:0] MubiTrue  = 4'b0110;

  localparam int unsigned NumClass   = 4;
  localparam int unsigned ClsFatalSw = 0;
  localparam int unsigned ClsRecovSw = 1;
  localparam int unsigned ClsFatalHw = 2;
  localparam int unsigned ClsRecovHw = 3;

  localparam int unsigned NumNmi   = 2;
  localparam int unsigned NmiAlert = 0;
  localparam int unsigned NmiWdog  = 1;

  localparam logic [7:0] OfsTest  = 8'h00;
  localparam logic [7:0] OfsRecov = 8'h04;
  localparam logic [7:0] OfsFatal = 8'h08;
  localparam logic [7:0] OfsNmiEn = 8'h4C;
  localparam logic [7:0] OfsNmiSt = 8'h50;

  typedef struct packed {
    logic test;
    logic recov;
    logic fatal;
    logic nmi_en;
    logic nmi_st;
  } reg_hit_t;

endpackage

// File: rtl/swalert_rst_sync.sv
module swalert_rst_sync #(
  parameter int unsigned Stages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [Stages-1:0] sync_q;
  logic [Stages-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[Stages-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[Stages-1];
endmodule

// File: rtl/swalert_mubi_fields.sv
module swalert_mubi_fields
  import swalert_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             recov_we_i,
  input  logic             fatal_we_i,
  input  logic [MubiW-1:0] wdata_i,
  output logic [MubiW-1:0] recov_o,
  output logic [MubiW-1:0] fatal_o,
  output logic             recov_fire_o,
  output logic             fatal_fire_o
);
  logic [MubiW-1:0] recov_q, recov_d;
  logic [MubiW-1:0] fatal_q, fatal_d;
  logic             recov_ce, fatal_ce;

  // Next state: recoverable field returns to false after firing; fatal field only loses bits.
  always_comb begin
    recov_fire_o = (recov_q != MubiFalse);
    recov_ce     = recov_we_i | recov_fire_o;
    recov_d      = recov_we_i ? wdata_i : MubiFalse;
    fatal_fire_o = (fatal_q != MubiFalse);
    fatal_ce     = fatal_we_i;
    fatal_d      = fatal_q & wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       recov_q <= MubiFalse;
    else if (recov_ce) recov_q <= recov_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fatal_q <= MubiFalse;
    else if (fatal_ce) fatal_q <= fatal_d;
  end

  assign recov_o = recov_q;
  assign fatal_o = fatal_q;

  // R3: a firing value is replaced by false unless software rewrites it
  p_recov_self_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recov_fire_o && !recov_we_i) |=> (recov_q == MubiFalse));

  // R3: an idle false field stays put
  p_recov_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!recov_fire_o && !recov_we_i) |=> $stable(recov_q));

  // R4: no bit of the fatal field ever goes from 0 to 1
  p_fatal_no_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fatal_q & ~$past(fatal_q)) == '0));

  // R5: once the fatal field is not false it never becomes false again
  p_fatal_stuck_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_fire_o |=> fatal_fire_o);
endmodule

// File: rtl/swalert_event_gen.sv
module swalert_event_gen #(
  parameter int unsigned NumCls = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_we_i,
  input  logic [NumCls-1:0] test_bits_i,
  input  logic [NumCls-1:0] cause_i,
  output logic [NumCls-1:0] evt_d_o,
  output logic [NumCls-1:0] evt_o
);
  for (genvar c = 0; c < NumCls; c++) begin : g_cls
    logic ev_d, ev_q;

    always_comb begin
      ev_d = (test_we_i & test_bits_i[c]) | cause_i[c];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ev_q <= 1'b0;
      else         ev_q <= ev_d;
    end

    assign evt_d_o[c] = ev_d;
    assign evt_o[c]   = ev_q;

    // R2: a test write of this class gives an event on the next cycle
    p_test_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (test_we_i && test_bits_i[c]) |=> evt_o[c]);

    // R6: without test write or cause, no event appears
    p_no_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(test_we_i && test_bits_i[c]) && !cause_i[c]) |=> !evt_o[c]);
  end
endmodule

// File: rtl/swalert_nmi_bank.sv
module swalert_nmi_bank #(
  parameter int unsigned NumSrc = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic              st_we_i,
  input  logic [NumSrc-1:0] wdata_i,
  input  logic [NumSrc-1:0] src_set_i,
  output logic [NumSrc-1:0] en_o,
  output logic [NumSrc-1:0] st_o,
  output logic              nmi_o
);
  for (genvar s = 0; s < NumSrc; s++) begin : g_src
    logic en_q, en_d, en_ce;
    logic st_q, st_d, st_ce, st_clr;

    always_comb begin
      en_ce  = en_we_i & wdata_i[s];
      en_d   = 1'b1;
      st_clr = st_we_i & wdata_i[s];
      st_ce  = src_set_i[s] | st_clr;
      st_d   = src_set_i[s];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    en_q <= 1'b0;
      else if (en_ce) en_q <= en_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q <= 1'b0;
      else if (st_ce) st_q <= st_d;
    end

    assign en_o[s] = en_q;
    assign st_o[s] = st_q;

    // R7: an enable never drops
    p_en_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_q |=> en_q);

    // R8: a set event always lands, even against a clear
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_set_i[s] |=> st_q);

    // R8: a clear without a competing set empties the bit
    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_we_i && wdata_i[s] && !src_set_i[s]) |=> !st_q);
  end

  assign nmi_o = |(st_o & en_o);

  // R9: only a state clear can withdraw a raised NMI
  p_nmi_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_o && !st_we_i) |=> nmi_o);
endmodule

// File: rtl/swalert_nmi_ctrl.sv
module swalert_nmi_ctrl
  import swalert_pkg::*;
#(
  parameter int unsigned AddrWidth = 8,
  parameter int unsigned DataWidth = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [AddrWidth-1:0] reg_addr_i,
  input  logic [DataWidth-1:0] reg_wdata_i,
  output logic [DataWidth-1:0] reg_rdata_o,
  input  logic                 core_minor_alert_i,
  input  logic                 core_major_int_alert_i,
  input  logic                 core_major_bus_alert_i,
  input  logic                 core_double_fault_i,
  input  logic                 bus_intg_err_i,
  input  logic                 wdog_nmi_i,
  output logic [NumClass-1:0]  alert_evt_o,
  output logic                 nmi_o
);
  localparam int unsigned UsedW = (MubiW > NumClass) ? MubiW : NumClass;

  logic             rst_sync_n;
  reg_hit_t         hit, wr;
  logic             any_hit;
  logic [MubiW-1:0] recov_val, fatal_val;
  logic             recov_fire, fatal_fire;
  logic [NumClass-1:0] cause, evt_d;
  logic [NumNmi-1:0]   nmi_set, nmi_en, nmi_st;
  logic                unused_wdata;

  swalert_rst_sync #(.Stages(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  // Address decode
  always_comb begin
    hit.test   = (reg_addr_i == AddrWidth'(OfsTest));
    hit.recov  = (reg_addr_i == AddrWidth'(OfsRecov));
    hit.fatal  = (reg_addr_i == AddrWidth'(OfsFatal));
    hit.nmi_en = (reg_addr_i == AddrWidth'(OfsNmiEn));
    hit.nmi_st = (reg_addr_i == AddrWidth'(OfsNmiSt));
    wr         = reg_we_i ? hit : '0;
    any_hit    = hit.recov | hit.fatal | hit.nmi_en | hit.nmi_st;
  end

  assign unused_wdata = ^reg_wdata_i[DataWidth-1:UsedW];

  swalert_mubi_fields u_fields (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .recov_we_i   (wr.recov),
    .fatal_we_i   (wr.fatal),
    .wdata_i      (reg_wdata_i[MubiW-1:0]),
    .recov_o      (recov_val),
    .fatal_o      (fatal_val),
    .recov_fire_o (recov_fire),
    .fatal_fire_o (fatal_fire)
  );

  always_comb begin
    cause             = '0;
    cause[ClsFatalSw] = fatal_fire;
    cause[ClsRecovSw] = recov_fire;
    cause[ClsFatalHw] = core_major_int_alert_i | core_major_bus_alert_i
                      | core_double_fault_i | bus_intg_err_i;
    cause[ClsRecovHw] = core_minor_alert_i;
  end

  swalert_event_gen #(.NumCls(NumClass)) u_events (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .test_we_i   (wr.test),
    .test_bits_i (reg_wdata_i[NumClass-1:0]),
    .cause_i     (cause),
    .evt_d_o     (evt_d),
    .evt_o       (alert_evt_o)
  );

  always_comb begin
    nmi_set           = '0;
    nmi_set[NmiAlert] = |evt_d;
    nmi_set[NmiWdog]  = wdog_nmi_i;
  end

  swalert_nmi_bank #(.NumSrc(NumNmi)) u_nmi (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .en_we_i   (wr.nmi_en),
    .st_we_i   (wr.nmi_st),
    .wdata_i   (reg_wdata_i[NumNmi-1:0]),
    .src_set_i (nmi_set),
    .en_o      (nmi_en),
    .st_o      (nmi_st),
    .nmi_o     (nmi_o)
  );

  // Read mux: reserved bits, the test register and unmapped offsets read zero
  always_comb begin
    reg_rdata_o = '0;
    if (hit.recov)  reg_rdata_o[MubiW-1:0]  = recov_val;
    if (hit.fatal)  reg_rdata_o[MubiW-1:0]  = fatal_val;
    if (hit.nmi_en) reg_rdata_o[NumNmi-1:0] = nmi_en;
    if (hit.nmi_st) reg_rdata_o[NumNmi-1:0] = nmi_st;
  end

  // R2, R10: offsets without readable state return zero
  p_reads_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !any_hit |-> (reg_rdata_o == '0));

  // R5: a non-false fatal field yields a fatal software event next cycle
  p_fatal_fires_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (fatal_val != MubiFalse) |=> alert_evt_o[ClsFatalSw]);

  // R6: hardware causes reach their class one cycle later
  p_fatal_hw_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (core_major_int_alert_i || core_major_bus_alert_i || core_double_fault_i
     || bus_intg_err_i) |=> alert_evt_o[ClsFatalHw]);

  p_recov_hw_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    core_minor_alert_i |=> alert_evt_o[ClsRecovHw]);

  // R8: the alert NMI state follows every alert event
  p_alert_state_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (|alert_evt_o) |-> nmi_st[NmiAlert]);
endmodule

// File: tb/tb_swalert_nmi_ctrl.sv
module tb_swalert_nmi_ctrl;
  localparam int ClkPeriod = 10;
  localparam int MaxCycles = 20000;
  localparam logic [3:0] FalseV = 4'h9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        minor, maj_int, maj_bus, dfault, intg, wdog;
  logic [3:0]  evt;
  logic        nmi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  swalert_nmi_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .core_minor_alert_i(minor), .core_major_int_alert_i(maj_int),
    .core_major_bus_alert_i(maj_bus), .core_double_fault_i(dfault),
    .bus_intg_err_i(intg), .wdog_nmi_i(wdog),
    .alert_evt_o(evt), .nmi_o(nmi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic hw_clear();
    minor = 0; maj_int = 0; maj_bus = 0; dfault = 0; intg = 0; wdog = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    we = 1'b0;
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  function automatic logic [3:0] exp_evt(input bit tw, input logic [3:0] tb,
                                         input bit mi, input bit fatal_any);
    logic [3:0] e;
    e = tw ? tb : 4'h0;
    e[2] = e[2] | fatal_any;
    e[3] = e[3] | mi;
    return e;
  endfunction

  function automatic logic [1:0] exp_state(input logic [1:0] st, input logic [1:0] clr,
                                           input logic [1:0] set);
    return (st & ~clr) | set;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (MaxCycles) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", MaxCycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  m_st, m_en, clr, setv;
    logic [3:0]  m_ev;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    hw_clear();
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    rd(8'h04, d); check("R1 recov field", d, 32'h9);
    rd(8'h08, d); check("R1 fatal field", d, 32'h9);
    rd(8'h4C, d); check("R1 nmi enable", d, 32'h0);
    rd(8'h50, d); check("R1 nmi state", d, 32'h0);
    check("R1 events", {28'h0, evt}, 32'h0);
    check("R1 nmi", {31'h0, nmi}, 32'h0);

    // R10 reserved and unmapped
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R10 unmapped read", d, 32'h0);
    check("R10 unmapped write no event", {28'h0, evt}, 32'h0);
    rd(8'h04, d); check("R10 unmapped write no field change", d, 32'h9);
    wr(8'h4C, 32'hFFFF_FFFC);
    rd(8'h4C, d); check("R10 reserved enable bits", d, 32'h0);
    wr(8'h04, 32'hFFFF_FFF9);
    rd(8'h04, d); check("R10 reserved field bits", d, 32'h9);
    step();
    check("R3 false write no event", {28'h0, evt}, 32'h0);

    // R8/R9/R7 watchdog source
    wdog = 1; step(); wdog = 0;
    rd(8'h50, d); check("R8 wdog sets state without enable", d, 32'h2);
    check("R9 nmi masked", {31'h0, nmi}, 32'h0);
    wr(8'h4C, 32'h2);
    check("R9 nmi enabled", {31'h0, nmi}, 32'h1);
    wr(8'h4C, 32'h0);
    rd(8'h4C, d); check("R7 enable not cleared", d, 32'h2);
    wdog = 1; we = 1; addr = 8'h50; wdata = 32'h2; step(); we = 0; wdog = 0;
    rd(8'h50, d); check("R8 set wins over clear", d, 32'h2);
    wr(8'h50, 32'h2);
    rd(8'h50, d); check("R8 w1c clear", d, 32'h0);
    check("R9 nmi drops", {31'h0, nmi}, 32'h0);

    // R2 test register
    for (int i = 0; i < 4; i++) begin
      wr(8'h00, 32'h1 << i);
      check("R2 test pulse", {28'h0, evt}, 32'h1 << i);
      step();
      check("R2 single pulse", {28'h0, evt}, 32'h0);
    end
    wr(8'h00, 32'hF);
    check("R2 all classes", {28'h0, evt}, 32'hF);
    rd(8'h00, d); check("R2 test reads zero", d, 32'h0);
    rd(8'h50, d); check("R8 alert state set by event", d, 32'h1);

    // R6 hardware causes
    for (int i = 0; i < 5; i++) begin
      hw_clear();
      case (i)
        0: maj_int = 1;
        1: maj_bus = 1;
        2: dfault = 1;
        3: intg = 1;
        default: minor = 1;
      endcase
      step();
      hw_clear();
      check("R6 hw cause", {28'h0, evt}, (i == 4) ? 32'h8 : 32'h4);
      step();
      check("R6 hw cause gone", {28'h0, evt}, 32'h0);
    end

    // R3 recoverable field
    for (int i = 0; i < 2; i++) begin
      wr(8'h04, (i == 0) ? 32'h6 : 32'h0);
      check("R3 no event at write", {28'h0, evt}, 32'h0);
      rd(8'h04, d); check("R3 value loaded", d, (i == 0) ? 32'h6 : 32'h0);
      step();
      check("R3 one event", {28'h0, evt}, 32'h2);
      rd(8'h04, d); check("R3 back to false", d, {28'h0, FalseV});
      step();
      check("R3 event ends", {28'h0, evt}, 32'h0);
    end
    wr(8'h50, 32'h1);
    rd(8'h50, d); check("R8 alert state cleared", d, 32'h0);

    // Random phase: test writes, NMI register writes, hardware causes
    m_st = 2'b00;
    m_en = 2'b10;
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [31:0] rw;
      op = $urandom % 4;
      rw = $urandom;
      minor   = ($urandom % 8) == 0;
      maj_int = ($urandom % 16) == 0;
      maj_bus = ($urandom % 16) == 0;
      dfault  = ($urandom % 16) == 0;
      intg    = ($urandom % 16) == 0;
      wdog    = ($urandom % 8) == 0;
      we    = (op != 0);
      addr  = (op == 1) ? 8'h00 : (op == 2) ? 8'h50 : (op == 3) ? 8'h4C : 8'h10;
      wdata = rw;
      m_ev = exp_evt(op == 1, rw[3:0], minor, maj_int | maj_bus | dfault | intg);
      clr  = (op == 2) ? rw[1:0] : 2'b00;
      setv = {wdog, |m_ev};
      m_st = exp_state(m_st, clr, setv);
      if (op == 3) m_en = m_en | rw[1:0];
      step();
      hw_clear();
      check("R6 R2 random events", {28'h0, evt}, {28'h0, m_ev});
      check("R9 random nmi", {31'h0, nmi}, {31'h0, |(m_st & m_en)});
      rd(8'h50, d); check("R8 random state", d, {30'h0, m_st});
    end
    hw_clear();
    rd(8'h4C, d); check("R7 random enable", d, {30'h0, m_en});

    // R4/R5 fatal field, last because it never stops firing
    wr(8'h08, 32'hF);
    rd(8'h08, d); check("R4 all-ones write keeps false", d, 32'h9);
    step();
    check("R5 no event while false", {31'h0, evt[0]}, 32'h0);
    wr(8'h08, 32'hE);
    rd(8'h08, d); check("R4 bit cleared", d, 32'h8);
    for (int i = 0; i < 5; i++) begin
      step();
      check("R5 fatal fires each cycle", {31'h0, evt[0]}, 32'h1);
    end
    wr(8'h08, 32'hF);
    rd(8'h08, d); check("R4 cleared bit not restored", d, 32'h8);
    wr(8'h08, 32'h1);
    rd(8'h08, d); check("R4 and with old value", d, 32'h0);
    check("R5 still firing", {31'h0, evt[0]}, 32'h1);
    wr(8'h4C, 32'h1);
    wr(8'h50, 32'h1);
    rd(8'h50, d); check("R8 set wins while fatal fires", {31'h0, d[0]}, 32'h1);
    check("R9 alert nmi", {31'h0, nmi}, 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule